// File: doc/BRIEF.md
# Byte-Addressable Bit-Bang Display-Link GPIO Register

This block is one 32-bit memory-mapped control word for a software-driven two-wire (I2C) display-data link. Software reaches it through a plain access port at four consecutive byte addresses. A write may be a byte, a halfword or a word, and it may start at any of the four addresses. Only the byte lanes that the access covers are merged into the stored word. A read returns the addressed lane in the low byte of the result. The clock and data input bits of a read come from the pins through two synchronising flops, not from storage.

The clock and data lines are open-drain. A line is pulled low only when its enable bit is set and its output bit is 0. Otherwise it is released. The bits that drive the pins are copied from the stored word only when a write can really change the bus. There are two such writes: a write that covers the lane holding the enable bits, and a write at the base byte while an enable bit is set. A driver that programs the word one byte at a time therefore causes no extra edges on the bus.

A build-time variant moves the enable bits up by one position. In that variant every pin refresh also needs a gate bit to be set. The access port has no back-pressure: every request is taken in the cycle where `acc_valid` is high, so the port has no ready signal. Read data comes back with `rd_valid` exactly one cycle after the request.

Top module: `ddc_gpio_reg`

## Requirements
- R1: After reset the stored word is zero and both lines are released (`scl_drive_low` = `sda_drive_low` = 0). `rd_valid` is 0. The input synchronisers reset to 1.
- R2: A request is accepted only when `acc_addr` lies between `BASE` and `BASE`+3. Any other request leaves the stored word and the pins unchanged and gives no `rd_valid`.
- R3: The starting lane of a write is `acc_addr`−`BASE`. The size code is 0 for a byte, 1 for a halfword, and 2 or 3 for a word. `acc_wdata[7:0]` goes to the starting lane and each following byte goes to the next lane up. Lanes past lane 3 are dropped. Lanes the write does not cover keep their value.
- R4: An accepted write that covers lane 2 copies the enable and output bits of the new word to the pins on the same clock edge.
- R5: An accepted write that starts at lane 0 and does not cover lane 2 copies the pins only when an enable bit of the merged word is set.
- R6: Any other write stores its data and leaves both pin drives unchanged.
- R7: With `MASKED`=0, the data and clock bits are: enables at bits 16 and 17, outputs at bits 0 and 1, inputs at bits 8 and 9. With `MASKED`=1 they are: enables at bits 17 and 18, outputs at bits 1 and 2, inputs at bits 9 and 10. In that case every refresh also needs bit 25 of the merged word to be 1.
- R8: A line is driven low exactly when its copied enable is 1 and its copied output is 0.
- R9: A read sets `rd_valid` on the next cycle. `rd_data` is then the stored word with its two input bits replaced by the synchronised pin levels, shifted right by 8 × the starting lane and zero-filled.
- R10: A pin level passes through two flops before a read can see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request, always accepted |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_wdata | input | 32 | Write data, aligned to the low byte |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data, addressed lane in the low byte |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |
| scl_drive_low | output | 1 | Pull clock line low |
| sda_drive_low | output | 1 | Pull data line low |

## Verification
The stored word and the pin drives change on the same edge that accepts a write, so they are due one cycle after the request is presented. Read data is due one cycle after the read request, with input levels that are two edges older than that. The bench keeps a behavioural model that is advanced on each rising edge from the inputs presented before that edge. It compares both variants of the block against the model on every falling edge. Stimulus is changed only on falling edges.

// File: rtl/ddc_gpio_pkg.sv
package ddc_gpio_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;
  localparam int OFFS_W  = $clog2(LANES);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // number of byte lanes an access of the given size spans
  function automatic logic [OFFS_W:0] span_of(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: span_of = (OFFS_W+1)'(1);
      SZ_HALF: span_of = (OFFS_W+1)'(2);
      default: span_of = (OFFS_W+1)'(LANES);
    endcase
  endfunction
endpackage

// File: rtl/ddc_lane_merge.sv
module ddc_lane_merge
  import ddc_gpio_pkg::*;
(
  input  logic [WORD_W-1:0] cur_word,
  input  logic [OFFS_W-1:0] offs,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] merged,
  output logic [LANES-1:0]  lane_hit
);
  logic [WORD_W-1:0] shifted;
  logic [OFFS_W:0]   span;

  assign shifted = wdata << {offs, 3'b000};
  assign span    = span_of(size);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFFS_W:0] GL = (OFFS_W+1)'(g);
    assign lane_hit[g] = (GL >= {1'b0, offs}) && ((GL - {1'b0, offs}) < span);
    assign merged[8*g +: 8] = lane_hit[g] ? shifted[8*g +: 8] : cur_word[8*g +: 8];
  end
endmodule

// File: rtl/ddc_update_qual.sv
module ddc_update_qual
  import ddc_gpio_pkg::*;
#(
  parameter bit MASKED  = 1'b0,
  parameter int EN_LANE = 2
) (
  input  logic             wr_hit,
  input  logic [LANES-1:0] lane_hit,
  input  logic [OFFS_W-1:0] offs,
  input  logic [1:0]       new_en,
  input  logic             gate_bit,
  output logic             refresh
);
  logic gate_ok;
  logic base_write;

  if (MASKED) begin : g_gate
    assign gate_ok = gate_bit;
  end else begin : g_nogate
    assign gate_ok = 1'b1;
  end

  assign base_write = (offs == '0) && (|new_en);
  assign refresh    = wr_hit && gate_ok && (lane_hit[EN_LANE] || base_write);

  // R4: write covering the enable lane refreshes whenever the gate allows
  always_comb begin
    if (wr_hit && lane_hit[EN_LANE] && (!MASKED || gate_bit))
      a_r4_enable_lane_refresh: assert (refresh);
  end
endmodule

// File: rtl/ddc_pin_drv.sv
module ddc_pin_drv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refresh,
  input  logic [1:0] new_en,   // [0] data, [1] clock
  input  logic [1:0] new_out,  // [0] data, [1] clock
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  output logic [1:0] pin_sync   // [0] data, [1] clock
);
  logic [1:0] en_q, out_q;
  logic [1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 2'b00;
      out_q <= 2'b00;
    end else if (refresh) begin
      en_q  <= new_en;
      out_q <= new_out;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= 2'b11;
      pin_sync <= 2'b11;
    end else begin
      meta_q   <= {scl_in, sda_in};
      pin_sync <= meta_q;
    end
  end

  assign sda_drive_low = en_q[0] & ~out_q[0];
  assign scl_drive_low = en_q[1] & ~out_q[1];

  // R6: drives only move on an edge that saw a refresh
  a_r6_drive_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> $stable({scl_drive_low, sda_drive_low}));

  // R8: after a refresh each drive follows enable and output of the copied word
  a_r8_drive_follows: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (scl_drive_low == ($past(new_en[1]) && !$past(new_out[1])))
             && (sda_drive_low == ($past(new_en[0]) && !$past(new_out[0]))));
endmodule

// File: rtl/ddc_gpio_reg.sv
module ddc_gpio_reg
  import ddc_gpio_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h0C0,
  parameter bit              MASKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);
  localparam int EN_LO    = MASKED ? 17 : 16;
  localparam int OUT_LO   = EN_LO - 16;
  localparam int IN_LO    = EN_LO - 8;
  localparam int EN_LANE  = EN_LO / 8;
  localparam int GATE_BIT = 25;
  localparam logic [ADDR_W-1:0] LAST = BASE + ADDR_W'(LANES - 1);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] view;
  logic [LANES-1:0]  lane_hit;
  logic [OFFS_W-1:0] offs;
  logic [ADDR_W-1:0] rel;
  logic              hit, wr_hit, rd_hit, refresh;
  logic [1:0]        pin_sync;

  assign hit    = acc_valid && (acc_addr >= BASE) && (acc_addr <= LAST);
  assign wr_hit = hit && acc_write;
  assign rd_hit = hit && !acc_write;
  assign rel    = acc_addr - BASE;
  assign offs   = rel[OFFS_W-1:0];

  ddc_lane_merge u_merge (
    .cur_word (word_q),
    .offs     (offs),
    .size     (acc_size),
    .wdata    (acc_wdata),
    .merged   (merged),
    .lane_hit (lane_hit)
  );

  ddc_update_qual #(.MASKED(MASKED), .EN_LANE(EN_LANE)) u_qual (
    .wr_hit   (wr_hit),
    .lane_hit (lane_hit),
    .offs     (offs),
    .new_en   (merged[EN_LO +: 2]),
    .gate_bit (merged[GATE_BIT]),
    .refresh  (refresh)
  );

  ddc_pin_drv u_pins (
    .clk           (clk),
    .rst_n         (rst_n),
    .refresh       (refresh),
    .new_en        (merged[EN_LO +: 2]),
    .new_out       (merged[OUT_LO +: 2]),
    .scl_in        (scl_in),
    .sda_in        (sda_in),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .pin_sync      (pin_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else if (wr_hit) word_q <= merged;
  end

  always_comb begin
    view = word_q;
    view[IN_LO +: 2] = pin_sync;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_hit;
      if (rd_hit) rd_data <= view >> {offs, 3'b000};
    end
  end

  // R2: requests outside the window change nothing and return nothing
  a_r2_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hit) |=> ($stable(word_q) && !rd_valid));

  // R3: a write not reaching lane 3 keeps the top byte
  a_r3_top_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !lane_hit[LANES-1]) |=> $stable(word_q[WORD_W-1 -: 8]));

  // R7: in the gated variant no refresh happens without the gate bit
  a_r7_gate_required: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && MASKED) |-> merged[GATE_BIT]);

  // R9: every accepted read is answered on the next cycle
  a_r9_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rd_valid);
endmodule

// File: tb/sim_ddc_gpio_reg.sv
module sim_ddc_gpio_reg;
  localparam time CLK_P = 10ns;
  localparam logic [11:0] BASE = 12'h0C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic ext_scl = 1'b1, ext_sda = 1'b1;

  logic [1:0]  rdv, scl_dl, sda_dl, scl_bus, sda_bus;
  logic [31:0] rdd [2];

  int compared = 0, mismatched = 0;
  string phase = "R1 reset";

  always #(CLK_P/2) clk = ~clk;

  assign scl_bus[0] = ext_scl & ~scl_dl[0];
  assign sda_bus[0] = ext_sda & ~sda_dl[0];
  assign scl_bus[1] = ext_scl & ~scl_dl[1];
  assign sda_bus[1] = ext_sda & ~sda_dl[1];

  ddc_gpio_reg #(.ADDR_W(12), .BASE(BASE), .MASKED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rdv[0]), .rd_data(rdd[0]), .scl_in(scl_bus[0]), .sda_in(sda_bus[0]),
    .scl_drive_low(scl_dl[0]), .sda_drive_low(sda_dl[0]));

  ddc_gpio_reg #(.ADDR_W(12), .BASE(BASE), .MASKED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rdv[1]), .rd_data(rdd[1]), .scl_in(scl_bus[1]), .sda_in(sda_bus[1]),
    .scl_drive_low(scl_dl[1]), .sda_drive_low(sda_dl[1]));

  // behavioural reference, one slot per variant
  bit [31:0] m_word [2];
  bit [1:0]  m_en [2], m_out [2], m_s1 [2], m_s2 [2];
  bit        m_rdv [2];
  bit [31:0] m_rdd [2];

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      int en_lo, in_lo, offs, span;
      bit [1:0] lvl;
      bit [31:0] nw, view;
      bit lane2, refresh, hit;
      en_lo = (v == 1) ? 17 : 16;
      in_lo = en_lo - 8;
      lvl[0] = ext_sda & !(m_en[v][0] & !m_out[v][0]);
      lvl[1] = ext_scl & !(m_en[v][1] & !m_out[v][1]);
      if (!rst_n) begin
        m_word[v] = 0; m_en[v] = 0; m_out[v] = 0;
        m_s1[v] = 2'b11; m_s2[v] = 2'b11; m_rdv[v] = 0; m_rdd[v] = 0;
      end else begin
        hit  = acc_valid && (int'(acc_addr) >= int'(BASE)) && (int'(acc_addr) <= int'(BASE) + 3);
        offs = int'(acc_addr) - int'(BASE);
        span = (acc_size == 0) ? 1 : (acc_size == 1) ? 2 : 4;
        view = m_word[v];
        view[in_lo] = m_s2[v][0];
        view[in_lo+1] = m_s2[v][1];
        m_rdv[v] = hit && !acc_write;
        if (hit && !acc_write) m_rdd[v] = view >> (8 * offs);
        if (hit && acc_write) begin
          nw = m_word[v];
          lane2 = 0;
          for (int k = 0; k < span; k++) begin
            if (offs + k < 4) begin
              nw[8*(offs+k) +: 8] = acc_wdata[8*k +: 8];
              if (offs + k == 2) lane2 = 1;
            end
          end
          refresh = (lane2 || (offs == 0 && (nw[en_lo] || nw[en_lo+1])))
                    && (v == 0 || nw[25]);
          m_word[v] = nw;
          if (refresh) begin
            m_en[v]  = {nw[en_lo+1], nw[en_lo]};
            m_out[v] = {nw[en_lo-15], nw[en_lo-16]};
          end
        end
        m_s2[v] = m_s1[v];
        m_s1[v] = lvl;
      end
    end
  end

  task automatic cmp(input string what, input int v, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s u%0d %s: actual %h expected %h", phase, v, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int v = 0; v < 2; v++) begin
        cmp("scl_drive_low", v, 32'(scl_dl[v]), 32'(m_en[v][1] & !m_out[v][1]));
        cmp("sda_drive_low", v, 32'(sda_dl[v]), 32'(m_en[v][0] & !m_out[v][0]));
        cmp("rd_valid", v, 32'(rdv[v]), 32'(m_rdv[v]));
        if (m_rdv[v]) cmp("rd_data", v, rdd[v], m_rdd[v]);
      end
    end
  end

  task automatic acc(input bit w, input int off, input bit [1:0] sz, input bit [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = 12'(int'(BASE) + off);
    acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic rd_all();
    for (int o = 0; o < 4; o++) acc(1'b0, o, 2'd0, 0);
    acc(1'b0, 0, 2'd2, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_P * 50000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1 reset state";
    for (int v = 0; v < 2; v++) begin
      cmp("scl released", v, 32'(scl_dl[v]), 0);
      cmp("sda released", v, 32'(sda_dl[v]), 0);
      cmp("rd_valid idle", v, 32'(rdv[v]), 0);
    end
    rd_all();

    phase = "R4 full word with enables";
    acc(1'b1, 0, 2'd2, 32'h0007_0007);
    rd_all();
    phase = "R5 base byte while enabled";
    acc(1'b1, 0, 2'd0, 32'h0000_0000);
    rd_all();
    phase = "R6 byte to lane 1 keeps pins";
    acc(1'b1, 1, 2'd0, 32'h0000_00A5);
    phase = "R6 byte to lane 3 keeps pins";
    acc(1'b1, 3, 2'd0, 32'h0000_005A);
    rd_all();
    phase = "R3 R4 halfword at lane 2";
    acc(1'b1, 2, 2'd1, 32'h0000_1201);
    rd_all();
    phase = "R3 R4 halfword straddling lanes 1-2";
    acc(1'b1, 1, 2'd1, 32'h0000_0200);
    phase = "R5 base byte releases";
    acc(1'b1, 0, 2'd0, 32'h0000_0003);
    rd_all();
    phase = "R3 word at lane 3 clipped";
    acc(1'b1, 3, 2'd2, 32'hDEAD_BE77);
    phase = "R3 word at lane 1";
    acc(1'b1, 1, 2'd2, 32'h0000_0000);
    phase = "R5 base byte with enables clear";
    acc(1'b1, 0, 2'd0, 32'h0000_0000);
    rd_all();

    phase = "R2 outside window ignored";
    acc(1'b1, -1, 2'd2, 32'hFFFF_FFFF);
    acc(1'b1, 4, 2'd2, 32'hFFFF_FFFF);
    acc(1'b0, 4, 2'd2, 0);
    acc(1'b0, -4, 2'd0, 0);
    rd_all();

    phase = "R7 enables without gate";
    acc(1'b1, 0, 2'd2, 32'h0006_0000);
    rd_all();
    phase = "R7 R8 enables with gate";
    acc(1'b1, 0, 2'd2, 32'h0206_0000);
    rd_all();
    phase = "R7 gate kept, base byte outputs high";
    acc(1'b1, 0, 2'd0, 32'h0000_0006);
    phase = "R7 R6 gate cleared by lane 3 only";
    acc(1'b1, 3, 2'd0, 32'h0000_0000);
    acc(1'b1, 0, 2'd0, 32'h0000_0000);
    rd_all();
    phase = "R8 data low clock released";
    acc(1'b1, 2, 2'd1, 32'h0201_0000 >> 16);
    acc(1'b1, 0, 2'd2, 32'h0203_0002);
    rd_all();

    phase = "R10 R9 external pull on clock";
    ext_scl = 1'b0;
    acc(1'b0, 1, 2'd0, 0);
    acc(1'b0, 1, 2'd0, 0);
    rd_all();
    phase = "R10 R9 external pull on data";
    ext_scl = 1'b1; ext_sda = 1'b0;
    rd_all();
    ext_sda = 1'b1;
    repeat (3) @(negedge clk);
    rd_all();

    phase = "R3 R9 halfword reads";
    acc(1'b1, 0, 2'd2, 32'h8421_C3F0);
    for (int o = 0; o < 4; o++) acc(1'b0, o, 2'd1, 0);

    phase = "R1 reset mid-run";
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 2; v++) cmp("scl released", v, 32'(scl_dl[v]), 0);
    rd_all();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule